// File: doc/BRIEF.md
# Segmentable Parity Reduction Unit

This block is a two-stage pipelined XOR engine for CRC and FEC datapaths that run at high rates. Each clock it accepts a 96-bit bundle split over three operands. A 30-bit `op_a` and an 18-bit `op_b` are joined into a 48-bit word, with `op_a` in the upper part. That word is XORed bit by bit with a 48-bit `op_c`. When accumulation is enabled, the unit's own registered 48-bit result is folded in as a third operand. This lets a parity be built up over several beats.

The 48-bit intermediate word is registered on `p_out`. It is also reduced into an 8-bit parity bus, `xor_out`, in one of two layouts. In the fine layout the bus carries eight independent parities, each covering 12 input bits. In the coarse layout it carries four 24-input parities, two 48-input parities and one parity over all 96 inputs, all at the same time. The mode select and the accumulate enable travel through the pipeline with their data.

Top module: `wide_xor_unit`

## Requirements
- R1: With accumulation off, `p_out` equals `{op_a, op_b} ^ op_c` as sampled two rising edges earlier. `op_a` occupies bits 47:18 and `op_b` bits 17:0.
- R2: With `acc_en` high when the data were sampled, `p_out` equals `{op_a, op_b} ^ op_c ^ P`. P is the value `p_out` held in the cycle before the update.
- R3: In fine mode (`mode_sel` = 0), `xor_out[k]` is the XOR of bits 6k+5..6k of the new 48-bit result, for k = 0..7.
- R4: In coarse mode (`mode_sel` = 1), bits 0, 2, 4 and 6 of `xor_out` are the XOR of result bits 11:0, 23:12, 35:24 and 47:36 respectively.
- R5: In coarse mode, `xor_out[1]` is the XOR of result bits 23:0 and `xor_out[5]` is the XOR of result bits 47:24.
- R6: In coarse mode, `xor_out[3]` is the XOR of all 48 result bits. With accumulation off, this is the parity of all 96 input bits.
- R7: In coarse mode, `xor_out[7]` is 0.
- R8: The mode select and accumulate enable are sampled in the same register stage as the data. A change in either applies exactly to the result of the data sampled alongside it, two edges later.
- R9: A synchronous active-high `rst` clears every pipeline register, including the accumulated result. `p_out` and `xor_out` read zero after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 30 | Upper part of the joined operand (bits 47:18) |
| op_b | input | 18 | Lower part of the joined operand (bits 17:0) |
| op_c | input | 48 | Second XOR operand |
| mode_sel | input | 1 | 0 = eight 12-input parities, 1 = coarse layout |
| acc_en | input | 1 | Fold the registered result back in as a third operand |
| p_out | output | 48 | Registered 48-bit bitwise XOR result |
| xor_out | output | 8 | Registered parity bus in the selected layout |

## Verification
The checker's timing properties assume the data, mode and accumulate inputs are settled and known at every rising edge once reset is released. They only judge a result after two clean edges have passed since reset, because only then has the pipeline been filled with real samples. The bench changes every input only on falling edges and drives all of them, including the control bits, on every cycle with known values. Random beats mix both layouts and turn accumulation on in about a third of cycles. Directed beats toggle the mode and the accumulate enable back to back, and apply a reset in the middle of an accumulation.

// File: rtl/wxor_pkg.sv
package wxor_pkg;

    // Default operand widths; the joined word is their sum.
    localparam int DEF_A_W = 30;
    localparam int DEF_B_W = 18;

    // The parity bus is fixed at eight lanes by the coarse bit placement.
    localparam int PAR_W = 8;

    // Coarse-layout lane positions.
    localparam int CO_HALF_LO_BIT = 1;
    localparam int CO_ALL_BIT     = 3;
    localparam int CO_HALF_HI_BIT = 5;
    localparam int CO_SPARE_BIT   = 7;

    typedef enum logic {
        SEG_FINE   = 1'b0,
        SEG_COARSE = 1'b1
    } seg_mode_e;

    // Lane that carries quarter q in the coarse layout.
    function automatic int quarter_lane(input int q);
        return 2 * q;
    endfunction

endpackage

// File: rtl/wxor_in_stage.sv
module wxor_in_stage
    import wxor_pkg::*;
#(
    parameter int A_W = DEF_A_W,
    parameter int B_W = DEF_B_W,
    localparam int W  = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] op_a,
    input  logic [B_W-1:0] op_b,
    input  logic [W-1:0]   op_c,
    input  logic           mode_sel,
    input  logic           acc_en,
    output logic [W-1:0]   ab_q,
    output logic [W-1:0]   c_q,
    output seg_mode_e      mode_q,
    output logic           acc_q
);

    // Data and controls share one register stage so they stay aligned.
    always_ff @(posedge clk) begin
        if (rst) begin
            ab_q   <= '0;
            c_q    <= '0;
            mode_q <= SEG_FINE;
            acc_q  <= 1'b0;
        end else begin
            ab_q   <= {op_a, op_b};
            c_q    <= op_c;
            mode_q <= seg_mode_e'(mode_sel);
            acc_q  <= acc_en;
        end
    end

endmodule

// File: rtl/wxor_accum.sv
module wxor_accum #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ab_q,
    input  logic [W-1:0] c_q,
    input  logic         acc_q,
    output logic [W-1:0] word_d,
    output logic [W-1:0] p_q
);

    logic [W-1:0] fb;

    // Feedback term is gated, not muxed into an operand, to keep one XOR3 level.
    always_comb begin
        fb     = acc_q ? p_q : '0;
        word_d = ab_q ^ c_q ^ fb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else begin
            p_q <= word_d;
        end
    end

endmodule

// File: rtl/wxor_reduce.sv
module wxor_reduce
    import wxor_pkg::*;
#(
    parameter int W  = 48,
    localparam int FS = W / PAR_W,
    localparam int QS = W / 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     word_d,
    input  seg_mode_e        mode_q,
    output logic [PAR_W-1:0] par_q
);

    logic [PAR_W-1:0] fine_v;
    logic [3:0]       quarter_v;
    logic [1:0]       half_v;
    logic             all_v;
    logic [PAR_W-1:0] coarse_v;

    // Leaf parities over the narrow slices.
    for (genvar k = 0; k < PAR_W; k++) begin : g_fine
        assign fine_v[k] = ^word_d[k*FS +: FS];
    end

    // Quarter parities; halves and total reuse them as a tree.
    for (genvar q = 0; q < 4; q++) begin : g_quarter
        assign quarter_v[q] = ^word_d[q*QS +: QS];
    end

    assign half_v[0] = quarter_v[0] ^ quarter_v[1];
    assign half_v[1] = quarter_v[2] ^ quarter_v[3];
    assign all_v     = half_v[0] ^ half_v[1];

    always_comb begin
        coarse_v = '0;
        for (int q = 0; q < 4; q++) begin
            coarse_v[quarter_lane(q)] = quarter_v[q];
        end
        coarse_v[CO_HALF_LO_BIT] = half_v[0];
        coarse_v[CO_HALF_HI_BIT] = half_v[1];
        coarse_v[CO_ALL_BIT]     = all_v;
        coarse_v[CO_SPARE_BIT]   = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= '0;
        end else if (mode_q == SEG_COARSE) begin
            par_q <= coarse_v;
        end else begin
            par_q <= fine_v;
        end
    end

endmodule

// File: rtl/wide_xor_unit.sv
module wide_xor_unit
    import wxor_pkg::*;
#(
    parameter int A_W = DEF_A_W,
    parameter int B_W = DEF_B_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [A_W-1:0]       op_a,
    input  logic [B_W-1:0]       op_b,
    input  logic [A_W+B_W-1:0]   op_c,
    input  logic                 mode_sel,
    input  logic                 acc_en,
    output logic [A_W+B_W-1:0]   p_out,
    output logic [PAR_W-1:0]     xor_out
);

    localparam int W = A_W + B_W;

    logic [W-1:0] ab_q;
    logic [W-1:0] c_q;
    seg_mode_e    mode_q;
    logic         acc_q;
    logic [W-1:0] word_d;

    wxor_in_stage #(.A_W(A_W), .B_W(B_W)) u_in (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_c     (op_c),
        .mode_sel (mode_sel),
        .acc_en   (acc_en),
        .ab_q     (ab_q),
        .c_q      (c_q),
        .mode_q   (mode_q),
        .acc_q    (acc_q)
    );

    wxor_accum #(.W(W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .ab_q   (ab_q),
        .c_q    (c_q),
        .acc_q  (acc_q),
        .word_d (word_d),
        .p_q    (p_out)
    );

    wxor_reduce #(.W(W)) u_red (
        .clk    (clk),
        .rst    (rst),
        .word_d (word_d),
        .mode_q (mode_q),
        .par_q  (xor_out)
    );

endmodule

// File: rtl/wxor_unit_chk.sv
module wxor_unit_chk #(
    parameter int W = 48
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] ab_in,
    input logic [W-1:0] c_in,
    input logic         mode_sel,
    input logic         acc_en,
    input logic [W-1:0] p_out,
    input logic [7:0]   xor_out
);

    localparam int FS = W / 8;
    localparam int QS = W / 4;
    localparam int HS = W / 2;

    logic [1:0] live = 2'd0;
    logic       rst_q = 1'b0;
    logic       vld;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            live <= 2'd0;
        end else if (live != 2'd3) begin
            live <= live + 2'd1;
        end
    end

    assign vld = (live >= 2'd2);

    function automatic logic [7:0] fold_fine(input logic [W-1:0] w);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < W; i++) begin
            r[i / FS] = r[i / FS] ^ w[i];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_CLEARS: assert (p_out == '0 && xor_out == '0); // R9
        end
    end

    AST_DIRECT_RESULT: assert property (@(posedge clk) disable iff (rst)
        (vld && !$past(acc_en, 2)) |-> p_out == $past(ab_in ^ c_in, 2)); // R1

    AST_ACCUM_RESULT: assert property (@(posedge clk) disable iff (rst)
        (vld && $past(acc_en, 2)) |-> p_out == ($past(ab_in ^ c_in, 2) ^ $past(p_out))); // R2

    AST_FINE_LANES: assert property (@(posedge clk) disable iff (rst)
        (vld && !$past(mode_sel, 2)) |-> xor_out == fold_fine(p_out)); // R3

    AST_QUARTER_LANES: assert property (@(posedge clk) disable iff (rst)
        (vld && $past(mode_sel, 2)) |->
        (xor_out[0] == ^p_out[0 +: QS] && xor_out[2] == ^p_out[QS +: QS] &&
         xor_out[4] == ^p_out[2*QS +: QS] && xor_out[6] == ^p_out[3*QS +: QS])); // R4

    AST_HALF_LANES: assert property (@(posedge clk) disable iff (rst)
        (vld && $past(mode_sel, 2)) |->
        (xor_out[1] == ^p_out[0 +: HS] && xor_out[5] == ^p_out[HS +: HS])); // R5

    AST_TOTAL_LANE: assert property (@(posedge clk) disable iff (rst)
        (vld && $past(mode_sel, 2)) |-> xor_out[3] == ^p_out); // R6

    AST_SPARE_LOW: assert property (@(posedge clk) disable iff (rst)
        (vld && $past(mode_sel, 2)) |-> !xor_out[7]); // R7

endmodule

bind wide_xor_unit wxor_unit_chk #(.W(A_W + B_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ab_in    ({op_a, op_b}),
    .c_in     (op_c),
    .mode_sel (mode_sel),
    .acc_en   (acc_en),
    .p_out    (p_out),
    .xor_out  (xor_out)
);

// File: tb/wide_xor_unit_tb.sv
module wide_xor_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] op_a = '0;
    logic [17:0] op_b = '0;
    logic [47:0] op_c = '0;
    logic        mode_sel = 1'b0;
    logic        acc_en = 1'b0;
    logic [47:0] p_out;
    logic [7:0]  xor_out;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string force_tag = "";

    typedef struct {
        logic [47:0] ab;
        logic [47:0] c;
        logic        coarse;
        logic        acc;
    } beat_t;

    beat_t       s1, s2;
    logic [47:0] model_p;

    always #2 clk = ~clk;

    wide_xor_unit u_dut (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_c     (op_c),
        .mode_sel (mode_sel),
        .acc_en   (acc_en),
        .p_out    (p_out),
        .xor_out  (xor_out)
    );

    // Reference parity bus computed bit by bit from the result word.
    function automatic logic [7:0] ref_par(input logic [47:0] w, input logic coarse);
        logic [7:0] r;
        r = '0;
        if (!coarse) begin
            for (int k = 0; k < 8; k++)
                for (int j = 0; j < 6; j++)
                    r[k] = r[k] ^ w[6*k + j];
        end else begin
            for (int i = 0; i < 48; i++) begin
                r[2*(i/12)] = r[2*(i/12)] ^ w[i];
                if (i < 24) r[1] = r[1] ^ w[i];
                else        r[5] = r[5] ^ w[i];
                r[3] = r[3] ^ w[i];
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string pick(input string t);
        return (force_tag != "") ? force_tag : t;
    endfunction

    task automatic clear_model();
        s1 = '{ab: '0, c: '0, coarse: 1'b0, acc: 1'b0};
        s2 = s1;
        model_p = '0;
    endtask

    // Called at a falling edge: check the beat driven two calls ago, then drive a new one.
    task automatic step(input logic [29:0] a, input logic [17:0] b, input logic [47:0] c,
                        input logic coarse, input logic acc);
        logic [47:0] ep;
        logic [7:0]  ex;
        ep = s2.ab ^ s2.c ^ (s2.acc ? model_p : 48'd0);
        model_p = ep;
        ex = ref_par(ep, s2.coarse);
        chk(pick(s2.acc ? "R2 accumulated p_out" : "R1 p_out"), 64'(p_out), 64'(ep));
        if (!s2.coarse) begin
            chk(pick("R3 fine lanes"), 64'(xor_out), 64'(ex));
        end else begin
            chk(pick("R4 quarter lanes"), 64'({xor_out[6], xor_out[4], xor_out[2], xor_out[0]}),
                64'({ex[6], ex[4], ex[2], ex[0]}));
            chk(pick("R5 half lanes"), 64'({xor_out[5], xor_out[1]}), 64'({ex[5], ex[1]}));
            chk(pick("R6 total lane"), 64'(xor_out[3]), 64'(ex[3]));
            chk(pick("R7 spare lane"), 64'(xor_out[7]), 64'd0);
        end
        s2 = s1;
        s1 = '{ab: {a, b}, c: c, coarse: coarse, acc: acc};
        op_a = a; op_b = b; op_c = c; mode_sel = coarse; acc_en = acc;
        @(negedge clk);
    endtask

    task automatic flush();
        for (int i = 0; i < 2; i++) step('0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 p_out after reset", 64'(p_out), 64'd0);
        chk("R9 xor_out after reset", 64'(xor_out), 64'd0);
        rst = 1'b0;
        clear_model();
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20517);
        clear_model();
        @(negedge clk);
        do_reset();

        // Directed corner cases in both layouts.
        step('0, '0, '0, 1'b0, 1'b0);
        step('1, '1, '0, 1'b0, 1'b0);
        step('1, '1, '0, 1'b1, 1'b0);
        step(30'h2000_0000, '0, '0, 1'b1, 1'b0);   // bit 47 only
        step('0, 18'h1, '0, 1'b0, 1'b0);          // bit 0 only
        step('0, '0, 48'h8000_0000_0000, 1'b1, 1'b0);
        step('1, '1, '1, 1'b1, 1'b0);             // operands cancel
        step('0, 18'h20000, 48'h0000_0004_0000, 1'b1, 1'b0); // bits 17 and 18
        flush();

        // R2: accumulate a chain of beats, then release.
        step(30'h1234_5678, 18'h2_3456, 48'hABCD_EF01_2345, 1'b1, 1'b1);
        step(30'h0F0F_0F0F, 18'h1_FFFF, 48'h0000_FFFF_0000, 1'b1, 1'b1);
        step(30'h3000_0001, 18'h0_0001, 48'h8000_0000_0001, 1'b0, 1'b1);
        step('0, '0, '0, 1'b0, 1'b1);
        step('0, '0, '0, 1'b1, 1'b0);
        flush();

        // R8: controls toggle every beat and must follow their own data.
        force_tag = "R8 control alignment";
        for (int i = 0; i < 16; i++)
            step(30'($urandom), 18'($urandom), {16'($urandom), 32'($urandom)},
                 1'(i % 2), 1'((i / 2) % 2));
        flush();
        force_tag = "";

        // R9: reset in the middle of an accumulation.
        for (int i = 0; i < 4; i++)
            step(30'($urandom), 18'($urandom), {16'($urandom), 32'($urandom)}, 1'b1, 1'b1);
        do_reset();
        flush();

        // Random mix.
        for (int i = 0; i < 3000; i++)
            step(30'($urandom), 18'($urandom), {16'($urandom), 32'($urandom)},
                 1'($urandom % 2), ($urandom % 3) == 0);
        flush();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule